// File: doc/BRIEF.md
# Lockable Two-Way Write-Back Cache

This block is a small set-associative data cache between a processor load/store port and a memory port that supports line bursts. Each processor request carries a cacheable flag from the address decoder. A cacheable request that hits completes in the cycle it is presented. A cacheable miss fetches the whole line with one burst and then completes as a hit. A dirty victim line is first written back with one burst. A request whose flag is clear goes straight to memory as a single-word transaction. It never looks up, hits or allocates a line.

A separate lock port lets software pin lines in the cache. A locked line is never picked as a victim. Locking an absent line first brings it in and then sets its lock bit. The victim is the first invalid unlocked way of the set. When every unlocked way is valid, the scan starts after the most recently used way, so with two ways the victim is the least recently used unlocked way. When every way of a set is locked, a cacheable miss to that set is served as an uncached single-word access. Addresses are word addresses, split from low to high into word offset, set index and tag. SETS, WAYS and words-per-line must be powers of two, and WAYS is 2 or 4. Both request ports hold their inputs steady until they see ready.

Top module: `lockable_cache`

## Requirements
- R1: A cacheable read or write whose line is resident completes with req_ready high in the same cycle req_valid is first presented, with read data on req_rdata, and it starts no memory transaction.
- R2: A cacheable miss fetches its line with exactly one read burst (mem_burst=1) of LINE_BYTES/(DATA_W/8) beats. The burst address is the line's first word, with the offset bits zero and the address steady for the whole burst. The request then returns the word's current value.
- R3: A cacheable write hit updates only the cache and marks the line dirty. When a dirty line is chosen as victim, it goes back to its own line address as one write burst before the new line's read burst, and memory then holds the written value.
- R4: A request with req_cacheable=0 is a single-word memory transaction (mem_burst=0) at req_addr. It neither hits nor allocates, so a later cacheable access to that word still misses.
- R5: A noncacheable write completes only in the cycle memory accepts its word, so memory holds the new value when req_ready is seen.
- R6: A locked line is never a victim. An invalid unlocked way is taken before any valid way, and a locked line stays resident across later misses to its set.
- R7: When every way of the indexed set is locked, a cacheable read or write miss is served as a single-word transaction and allocates nothing.
- R8: The lock port takes lk_lock=1 to lock and 0 to unlock, and lk_ready acknowledges the request. Locking an absent line fills it first. Unlocking an absent line, or locking while every way of the set is locked, is acknowledged with no memory traffic. Processor requests take priority over the lock port.
- R9: With no locks, a miss to a full set evicts the least recently used way, where a hit or a fill makes its way the most recently used.
- R10: After reset every line is invalid and unlocked, mem_req and req_ready are low, and the first cacheable access misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request completes this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_cacheable | input | 1 | Region attribute, 1 = may be cached |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_rdata | output | DATA_W | Read data, valid with req_ready |
| lk_valid | input | 1 | Lock/unlock request present |
| lk_lock | input | 1 | 1 = lock, 0 = unlock |
| lk_addr | input | ADDR_W | Word address inside the target line |
| lk_ready | output | 1 | Lock request done this cycle |
| mem_req | output | 1 | Memory transaction in progress |
| mem_we | output | 1 | Transaction writes memory |
| mem_burst | output | 1 | 1 = whole-line burst, 0 = single word |
| mem_addr | output | ADDR_W | Start word address, steady during the transaction |
| mem_wdata | output | DATA_W | Current write beat |
| mem_wready | input | 1 | Memory takes the current write beat |
| mem_rvalid | input | 1 | Memory delivers the next read beat |
| mem_rdata | input | DATA_W | Read beat data |

## Verification
The bench counts every memory transaction by kind: read burst, write burst and single word. Each access is therefore judged by both its returned data and its traffic. Cold misses, repeated hits and a write hit tell allocation apart from hits and show that writes stay in the cache. Access orders that alternate recency in one set show whether the victim follows least-recent use and whether a dirty line is written back to its own address. Noncacheable reads made around a memory change behind the cache, a fully locked set, and lock, unlock and re-lock sequences show that bypass never allocates, that locked lines survive misses and that lock traffic occurs only for an absent line.

// File: rtl/lockable_cache.sv
module lockable_cache #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic              req_cacheable,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] req_rdata,
  input  logic              lk_valid,
  input  logic              lk_lock,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_burst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_wready,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int WORDS = LINE_BYTES / (DATA_W / 8);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int LINES = WAYS * SETS;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_BYP} state_t;

  state_t            st_q;
  logic [WAY_W-1:0]  vic_q;
  logic [TAG_W-1:0]  otag_q, vtag_q;
  logic [IDX_W-1:0]  oset_q;
  logic [OFF_W-1:0]  cnt_q;

  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES*WORDS];
  logic [LINES-1:0]  val_q, dty_q, lck_q;
  logic [WAY_W-1:0]  mru_q [SETS];

  logic [ADDR_W-1:0] look;
  logic [TAG_W-1:0]  l_tag;
  logic [IDX_W-1:0]  l_set;
  logic [OFF_W-1:0]  l_off;
  logic              hit, found;
  logic [WAY_W-1:0]  hway, vway;

  assign look  = req_valid ? req_addr : lk_addr;
  assign l_tag = look[ADDR_W-1 -: TAG_W];
  assign l_set = look[OFF_W +: IDX_W];
  assign l_off = look[OFF_W-1:0];

  always_comb begin
    logic [WAY_W-1:0] cw;
    hit   = 1'b0;
    hway  = '0;
    found = 1'b0;
    vway  = '0;
    for (int w = 0; w < WAYS; w++) begin
      cw = WAY_W'(w);
      if (val_q[{cw, l_set}] && tag_q[{cw, l_set}] == l_tag) begin
        hit  = 1'b1;
        hway = cw;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      cw = WAY_W'(w);
      if (!found && !val_q[{cw, l_set}] && !lck_q[{cw, l_set}]) begin
        found = 1'b1;
        vway  = cw;
      end
    end
    for (int k = 1; k <= WAYS; k++) begin
      cw = mru_q[l_set] + WAY_W'(k);
      if (!found && !lck_q[{cw, l_set}]) begin
        found = 1'b1;
        vway  = cw;
      end
    end
  end

  logic cpu_hit, lk_go, start_fill, start_byp;

  assign cpu_hit    = (st_q == S_IDLE) && req_valid && req_cacheable && hit;
  assign lk_go      = (st_q == S_IDLE) && !req_valid && lk_valid;
  assign start_byp  = (st_q == S_IDLE) && req_valid && (!req_cacheable || (!hit && !found));
  assign start_fill = (st_q == S_IDLE) && !hit && found &&
                      ((req_valid && req_cacheable) || (lk_go && lk_lock));

  assign req_ready = cpu_hit || ((st_q == S_BYP) && (req_we ? mem_wready : mem_rvalid));
  assign req_rdata = (st_q == S_BYP) ? mem_rdata : dat_q[{hway, l_set, l_off}];
  assign lk_ready  = lk_go && (hit || !lk_lock || !found);

  assign mem_req   = (st_q != S_IDLE);
  assign mem_burst = (st_q == S_WB) || (st_q == S_FILL);
  assign mem_we    = (st_q == S_WB) || ((st_q == S_BYP) && req_we);
  assign mem_addr  = (st_q == S_BYP) ? req_addr
                   : {((st_q == S_WB) ? vtag_q : otag_q), oset_q, {OFF_W{1'b0}}};
  assign mem_wdata = (st_q == S_WB) ? dat_q[{vic_q, oset_q, cnt_q}] : req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      vic_q  <= '0;
      otag_q <= '0;
      vtag_q <= '0;
      oset_q <= '0;
      cnt_q  <= '0;
      val_q  <= '0;
      dty_q  <= '0;
      lck_q  <= '0;
      for (int s = 0; s < SETS; s++) mru_q[s] <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (start_byp) begin
            st_q <= S_BYP;
          end else if (start_fill) begin
            vic_q  <= vway;
            otag_q <= l_tag;
            oset_q <= l_set;
            vtag_q <= tag_q[{vway, l_set}];
            cnt_q  <= '0;
            st_q   <= (val_q[{vway, l_set}] && dty_q[{vway, l_set}]) ? S_WB : S_FILL;
          end
          if (cpu_hit) begin
            mru_q[l_set] <= hway;
            if (req_we) dty_q[{hway, l_set}] <= 1'b1;
          end
          if (lk_ready && hit) lck_q[{hway, l_set}] <= lk_lock;
        end
        S_WB: if (mem_wready) begin
          cnt_q <= cnt_q + 1'b1;
          if (&cnt_q) st_q <= S_FILL;
        end
        S_FILL: if (mem_rvalid) begin
          cnt_q <= cnt_q + 1'b1;
          if (&cnt_q) begin
            val_q[{vic_q, oset_q}] <= 1'b1;
            dty_q[{vic_q, oset_q}] <= 1'b0;
            lck_q[{vic_q, oset_q}] <= 1'b0;
            mru_q[oset_q]          <= vic_q;
            st_q                   <= S_IDLE;
          end
        end
        default: if (req_ready) st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_hit && req_we) dat_q[{hway, l_set, l_off}] <= req_wdata;
    if (st_q == S_FILL && mem_rvalid) begin
      dat_q[{vic_q, oset_q, cnt_q}] <= mem_rdata;
      if (&cnt_q) tag_q[{vic_q, oset_q}] <= otag_q;
    end
  end
endmodule

// File: rtl/lockable_cache_chk.sv
module lockable_cache_chk #(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 2,
  parameter int WAY_W  = 1,
  parameter int LINES  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic              req_cacheable,
  input logic [ADDR_W-1:0] req_addr,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_burst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LINES-1:0]  lck_vec,
  input logic [WAY_W-1:0]  vic
);
  a_r2_burst_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_burst) |-> (mem_addr[OFF_W-1:0] == '0));

  a_r2_burst_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_burst && $past(mem_req) && $past(mem_burst) && $past(mem_we) == mem_we)
      |-> $stable(mem_addr));

  a_r4_single_at_req_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_burst) |-> (req_valid && mem_addr == req_addr));

  a_r5_nc_write_in_memory: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_we && !req_cacheable) |-> (mem_req && mem_we && !mem_burst));

  a_r6_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_burst) |-> !lck_vec[{vic, mem_addr[OFF_W +: IDX_W]}]);

  a_r8_cpu_first: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ready |-> (lk_valid && !req_valid && !req_ready));
endmodule

bind lockable_cache lockable_cache_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .WAY_W(WAY_W), .LINES(LINES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_we(req_we), .req_cacheable(req_cacheable), .req_addr(req_addr),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .mem_req(mem_req), .mem_we(mem_we),
  .mem_burst(mem_burst), .mem_addr(mem_addr), .lck_vec(lck_q), .vic(vic_q)
);

// File: tb/sim_lockable_cache.sv
module sim_lockable_cache;
  localparam int AW = 10, DW = 32, WORDS = 4, LAT = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, req_cacheable = 0;
  logic [AW-1:0] req_addr = '0, lk_addr = '0;
  logic [DW-1:0] req_wdata = '0, req_rdata, mem_wdata, mem_rdata;
  logic req_ready, lk_valid = 0, lk_lock = 0, lk_ready;
  logic mem_req, mem_we, mem_burst, mem_wready, mem_rvalid;
  logic [AW-1:0] mem_addr;

  always #5 clk = ~clk;

  lockable_cache u0 (.*);

  logic [DW-1:0] mem [1024];
  logic [DW-1:0] ref_mem [1024];
  int n_chk = 0, n_fail = 0, n_rb = 0, n_wb = 0, n_sw = 0;
  logic [DW-1:0] exp_q [$];
  string rq_q [$];

  logic act = 0, m_we = 0, wr_q = 0, rv_q = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] rd_q = '0;
  int m_len = 0, beat = 0, wt = 0;
  assign mem_wready = wr_q;
  assign mem_rvalid = rv_q;
  assign mem_rdata  = rd_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      act <= 0; wr_q <= 0; rv_q <= 0;
    end else begin
      if (wr_q) mem[m_addr + AW'(beat - 1)] <= mem_wdata;
      if (!act) begin
        rv_q <= 0; wr_q <= 0;
        if (mem_req) begin
          act <= 1; m_addr <= mem_addr; m_we <= mem_we;
          m_len <= mem_burst ? WORDS : 1; beat <= 0; wt <= LAT;
          if (!mem_burst) n_sw++;
          else if (mem_we) n_wb++;
          else n_rb++;
        end
      end else if (wt != 0) begin
        wt <= wt - 1;
      end else if (beat < m_len) begin
        beat <= beat + 1;
        if (m_we) wr_q <= 1;
        else begin rv_q <= 1; rd_q <= mem[m_addr + AW'(beat)]; end
      end else begin
        rv_q <= 0; wr_q <= 0; act <= 0;
      end
    end
  end

  task automatic check(input bit ok, input string r, input int actv, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, actv, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready && !req_we) begin
      if (exp_q.size() == 0) check(0, "scoreboard", 0, 1);
      else begin
        logic [DW-1:0] e;
        string r;
        e = exp_q.pop_front();
        r = rq_q.pop_front();
        check(req_rdata == e, r, int'(req_rdata), int'(e));
      end
    end
  end

  int s_rb, s_wb, s_sw;
  task automatic snap();
    s_rb = n_rb; s_wb = n_wb; s_sw = n_sw;
  endtask
  task automatic traffic(input string r, input int rb, input int wb, input int sw);
    int a, e;
    a = (n_rb - s_rb) * 100 + (n_wb - s_wb) * 10 + (n_sw - s_sw);
    e = rb * 100 + wb * 10 + sw;
    check(a == e, r, a, e);
  endtask

  task automatic cpu(input bit we, input int a, input logic [DW-1:0] d, input bit c,
                     input string r, output int cyc);
    snap();
    if (!we) begin exp_q.push_back(ref_mem[a]); rq_q.push_back(r); end
    else ref_mem[a] = d;
    @(posedge clk); #1;
    req_valid = 1; req_we = we; req_addr = AW'(a); req_wdata = d; req_cacheable = c;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic lk(input int a, input bit lock);
    snap();
    @(posedge clk); #1;
    lk_valid = 1; lk_lock = lock; lk_addr = AW'(a);
    forever begin
      @(negedge clk);
      if (lk_ready) break;
    end
    @(posedge clk); #1;
    lk_valid = 0;
  endtask

  task automatic finish_run();
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    check(0, "watchdog", 1, 0);
    finish_run();
  end

  initial begin
    int c;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 32'hA000_0000 + i;
      ref_mem[i] = 32'hA000_0000 + i;
    end
    repeat (3) @(posedge clk);
    #1;
    check(!mem_req && !req_ready, "R10 reset idle", {mem_req, req_ready}, 0);
    rst_n = 1;

    cpu(0, 'h000, 0, 1, "R2 R10 cold miss", c);
    traffic("R2 one line burst", 1, 0, 0);
    cpu(0, 'h001, 0, 1, "R1 hit", c);
    check(c == 1, "R1 hit same cycle", c, 1);
    traffic("R1 no traffic on hit", 0, 0, 0);
    cpu(1, 'h002, 32'h1111_2222, 1, "R3 write hit", c);
    traffic("R3 write hit stays in cache", 0, 0, 0);
    cpu(0, 'h002, 0, 1, "R3 read written", c);

    cpu(0, 'h010, 0, 1, "R6 fill invalid way", c);
    traffic("R6 invalid way no writeback", 1, 0, 0);
    cpu(0, 'h000, 0, 1, "R6 first line kept", c);
    traffic("R6 first line still hits", 0, 0, 0);
    cpu(0, 'h020, 0, 1, "R9 miss on full set", c);
    traffic("R9 clean lru victim", 1, 0, 0);
    cpu(0, 'h003, 0, 1, "R9 mru line kept", c);
    traffic("R9 mru line hits", 0, 0, 0);
    cpu(0, 'h011, 0, 1, "R9 lru line refetched", c);
    traffic("R9 evicted line misses", 1, 0, 0);
    cpu(0, 'h020, 0, 1, "R3 dirty eviction", c);
    traffic("R3 writeback then fill", 1, 1, 0);
    check(mem[2] == 32'h1111_2222, "R3 written back", int'(mem[2]), 32'h1111_2222);

    cpu(0, 'h005, 0, 0, "R4 nc read", c);
    traffic("R4 single word", 0, 0, 1);
    mem[5] = 32'h5555_0005; ref_mem[5] = 32'h5555_0005;
    cpu(0, 'h005, 0, 0, "R4 nc read sees memory", c);
    traffic("R4 single word again", 0, 0, 1);
    cpu(0, 'h005, 0, 1, "R4 cacheable after nc", c);
    traffic("R4 nothing allocated", 1, 0, 0);

    cpu(1, 'h036, 32'hBEEF_0036, 0, "R5 nc write", c);
    traffic("R5 single write", 0, 0, 1);
    check(mem['h36] == 32'hBEEF_0036, "R5 in memory at ready", int'(mem['h36]), 32'hBEEF_0036);
    cpu(0, 'h036, 0, 1, "R5 read back", c);

    lk('h040, 1);
    traffic("R8 lock absent fills", 1, 0, 0);
    cpu(0, 'h041, 0, 1, "R8 locked line present", c);
    traffic("R8 locked line hits", 0, 0, 0);
    cpu(0, 'h010, 0, 1, "R6 miss with lock", c);
    traffic("R6 unlocked way used", 1, 0, 0);
    cpu(0, 'h050, 0, 1, "R6 miss evicts mru unlocked", c);
    traffic("R6 fill", 1, 0, 0);
    cpu(0, 'h040, 0, 1, "R6 locked survives", c);
    traffic("R6 locked line still hits", 0, 0, 0);

    lk('h050, 1);
    traffic("R8 lock present no traffic", 0, 0, 0);
    cpu(0, 'h060, 0, 1, "R7 all locked read", c);
    traffic("R7 single word", 0, 0, 1);
    cpu(0, 'h060, 0, 1, "R7 read again", c);
    traffic("R7 not allocated", 0, 0, 1);
    cpu(1, 'h061, 32'hCAFE_0061, 1, "R7 all locked write", c);
    traffic("R7 single write", 0, 0, 1);
    check(mem['h61] == 32'hCAFE_0061, "R7 write in memory", int'(mem['h61]), 32'hCAFE_0061);
    cpu(0, 'h051, 0, 1, "R7 locked lines intact", c);
    traffic("R7 locked hit", 0, 0, 0);

    lk('h070, 1);
    traffic("R8 lock with set full of locks", 0, 0, 0);
    lk('h040, 0);
    traffic("R8 unlock present", 0, 0, 0);
    cpu(0, 'h060, 0, 1, "R8 unlocked way reusable", c);
    traffic("R8 fill after unlock", 1, 0, 0);
    cpu(0, 'h052, 0, 1, "R8 other lock kept", c);
    traffic("R8 locked hit", 0, 0, 0);
    lk('h0F0, 0);
    traffic("R8 unlock absent", 0, 0, 0);
    cpu(0, 'h040, 0, 1, "R8 unlocked line evicted", c);
    traffic("R8 unlocked line misses", 1, 0, 0);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule